// File: doc/BRIEF.md
# Word-over-Byte Memory Port

This block is a single byte-wide storage array reached through two paths. The fetch path returns one byte at a byte address, which is how an instruction stream is read. The word path reads or writes a 32-bit word at a word address. The block multiplies that address by four to find the first byte of the word, and it lays the word out most significant byte first.

Each cycle the block serves at most one request. A word access takes precedence over a fetch made in the same cycle, and the fetch is not served. A write takes precedence over a read made in the same cycle. One clock after a request is served, the result appears together with a one-cycle `valid` pulse. A request that reaches past the last byte of the array completes nothing and raises a one-cycle `err` pulse instead. After reset the array holds a parameter image in its lowest bytes and zero everywhere else.

Top module: `wob_mem`

## Requirements
- R1: While reset is high and in the first cycle after it, `valid`, `err`, `rdata` and `fetch_byte` are all zero.
- R2: Word address W covers byte addresses 4W, 4W+1, 4W+2 and 4W+3 and no other bytes. Writing word W leaves bytes 4W-1 and 4W+4 unchanged.
- R3: A word write stores `wdata[31:24]` at byte 4W, `wdata[23:16]` at 4W+1, `wdata[15:8]` at 4W+2 and `wdata[7:0]` at 4W+3.
- R4: A word read of W puts byte 4W on `rdata[31:24]` down to byte 4W+3 on `rdata[7:0]`, one clock after the request, with `valid` high for that cycle.
- R5: A fetch returns exactly the byte at `fetch_addr` on `fetch_byte`, one clock after the request, with `valid` high for that cycle.
- R6: A byte that has never been written and lies outside the image reads as zero through both paths.
- R7: After reset, byte i holds `IMAGE[8i+7:8i]` for each i below `IMAGE_LEN`.
- R8: A fetch with `fetch_addr` greater than DEPTH-1 raises `err` one clock later. In that cycle `valid` stays low and `fetch_byte` keeps its value.
- R9: A word access with 4W+3 greater than DEPTH-1 raises `err` one clock later, with `valid` low. Such a write changes no byte, including the bytes of the word that lie inside the array. Such a read leaves `rdata` unchanged.
- R10: If a fetch and a word access are requested in the same cycle, only the word access is served, and `fetch_byte` keeps its value.
- R11: If the read and write strobes are both high, only the write is performed, and `rdata` keeps its value.
- R12: `valid` and `err` are never high together. Each is a single-cycle pulse and stays low after a cycle with no request. `rdata` and `fetch_byte` hold their values until the next successful read or fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; reloads the image |
| fetch_req | input | 1 | Request a byte fetch |
| fetch_addr | input | ADDR_W | Byte address for the fetch |
| rd_stb | input | 1 | Request a word read |
| wr_stb | input | 1 | Request a word write |
| word_addr | input | ADDR_W | Word address, scaled by four inside the block |
| wdata | input | 32 | Word to write |
| fetch_byte | output | 8 | Byte returned by the last successful fetch |
| rdata | output | 32 | Word returned by the last successful read |
| valid | output | 1 | One-cycle pulse: the previous cycle's request completed |
| err | output | 1 | One-cycle pulse: the previous cycle's request was out of range |

## Verification
The bench sets the depth to a value that is not a multiple of four. This places the last word address across the end of the array, so that word is only partly in range. A design that tested only the first byte would write the two bytes that are still inside the array; the bench catches this by fetching those bytes afterwards. The bench writes a word and then fetches the bytes on both sides of it and within it. Reversed lanes, or a missing scale by four, show up as the wrong byte at the wrong address. Same-cycle collisions are also driven: a fetch together with a read, and a read together with a write. A wrong priority would change `fetch_byte`, or would return stale read data in place of performing the write. The fetch bound is tested at DEPTH-1 and at DEPTH, which exposes an off-by-one in the limit check.

// File: rtl/wob_pkg.sv
package wob_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;

    // One served operation per cycle
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FETCH = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } op_e;

    // Result registers of the port
    typedef struct packed {
        logic              valid;
        logic              err;
        logic [WORD_W-1:0] word;
        logic [BYTE_W-1:0] fbyte;
    } result_t;

    // Lane k of a word, counted from the most significant byte
    function automatic logic [BYTE_W-1:0] lane_of(input logic [WORD_W-1:0] w, input int k);
        return w[WORD_W-1-BYTE_W*k -: BYTE_W];
    endfunction

endpackage

// File: rtl/wob_arbiter.sv
module wob_arbiter
    import wob_pkg::*;
#(
    parameter int ADDR_W = 13,
    localparam int BW = ADDR_W + 2
) (
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] word_addr,
    output op_e               op,
    output logic [BW-1:0]     base
);
    // Write beats read, any word access beats fetch
    always_comb begin
        op   = OP_IDLE;
        base = '0;
        if (wr_stb) begin
            op   = OP_WRITE;
            base = {word_addr, 2'b00};
        end else if (rd_stb) begin
            op   = OP_READ;
            base = {word_addr, 2'b00};
        end else if (fetch_req) begin
            op   = OP_FETCH;
            base = {2'b00, fetch_addr};
        end
    end
endmodule

// File: rtl/wob_bounds.sv
module wob_bounds
    import wob_pkg::*;
#(
    parameter int DEPTH  = 5000,
    parameter int ADDR_W = 13,
    localparam int BW = ADDR_W + 2
) (
    input  op_e           op,
    input  logic [BW-1:0] base,
    output logic          ok
);
    localparam logic [BW-1:0] LAST = BW'(DEPTH - 1);
    localparam logic [BW-1:0] SPAN = BW'(WORD_BYTES - 1);

    // A word is legal only if its final byte is inside the array
    always_comb begin
        unique case (op)
            OP_FETCH:          ok = (base <= LAST);
            OP_READ, OP_WRITE: ok = ((base + SPAN) <= LAST);
            default:           ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/wob_store.sv
module wob_store
    import wob_pkg::*;
#(
    parameter int DEPTH     = 5000,
    parameter int ADDR_W    = 13,
    parameter int IMAGE_LEN = 8,
    parameter logic [IMAGE_LEN*BYTE_W-1:0] IMAGE = '0,
    localparam int BW = ADDR_W + 2,
    localparam int MW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [BW-1:0]     base,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word_out,
    output logic [BYTE_W-1:0] byte_out
);
    logic [BYTE_W-1:0] cells [DEPTH];

    function automatic logic [BYTE_W-1:0] image_byte(input int i);
        if (i < IMAGE_LEN) return IMAGE[BYTE_W*i +: BYTE_W];
        return '0;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= image_byte(i);
        end else if (we) begin
            for (int k = 0; k < WORD_BYTES; k++) begin
                cells[MW'(base + BW'(k))] <= lane_of(wdata, k);
            end
        end
    end

    // Read lanes; any index past the end yields zero
    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
        logic [BW-1:0] idx;
        assign idx = base + BW'(k);
        assign word_out[WORD_W-1-BYTE_W*k -: BYTE_W] =
            (idx < BW'(DEPTH)) ? cells[MW'(idx)] : '0;
    end

    assign byte_out = word_out[WORD_W-1 -: BYTE_W];
endmodule

// File: rtl/wob_mem.sv
module wob_mem
    import wob_pkg::*;
#(
    parameter int DEPTH     = 5000,
    parameter int ADDR_W    = 13,
    parameter int IMAGE_LEN = 8,
    parameter logic [IMAGE_LEN*8-1:0] IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [31:0]       wdata,
    output logic [7:0]        fetch_byte,
    output logic [31:0]       rdata,
    output logic              valid,
    output logic              err
);
    localparam int BW = ADDR_W + 2;

    op_e               op;
    logic [BW-1:0]     base;
    logic              ok;
    logic [WORD_W-1:0] word_out;
    logic [BYTE_W-1:0] byte_out;
    result_t           res_q;

    wob_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .fetch_req (fetch_req),
        .fetch_addr(fetch_addr),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .word_addr (word_addr),
        .op        (op),
        .base      (base)
    );

    wob_bounds #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_bnd (
        .op  (op),
        .base(base),
        .ok  (ok)
    );

    wob_store #(
        .DEPTH    (DEPTH),
        .ADDR_W   (ADDR_W),
        .IMAGE_LEN(IMAGE_LEN),
        .IMAGE    (IMAGE)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (op == OP_WRITE && ok),
        .base    (base),
        .wdata   (wdata),
        .word_out(word_out),
        .byte_out(byte_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= (op != OP_IDLE) && ok;
            res_q.err   <= (op != OP_IDLE) && !ok;
            if (op == OP_READ && ok)  res_q.word  <= word_out;
            if (op == OP_FETCH && ok) res_q.fbyte <= byte_out;
        end
    end

    assign valid      = res_q.valid;
    assign err        = res_q.err;
    assign rdata      = res_q.word;
    assign fetch_byte = res_q.fbyte;
endmodule

// File: rtl/wob_mem_chk.sv
module wob_mem_chk #(
    parameter int DEPTH  = 5000,
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] word_addr,
    input logic [7:0]        fetch_byte,
    input logic [31:0]       rdata,
    input logic              valid,
    input logic              err
);
    logic [31:0] last_byte_of_word;
    logic        word_oob;
    logic        fetch_oob;
    logic        any_word;

    assign last_byte_of_word = 32'(word_addr) * 32'd4 + 32'd3;
    assign word_oob  = last_byte_of_word >= 32'(DEPTH);
    assign fetch_oob = 32'(fetch_addr) >= 32'(DEPTH);
    assign any_word  = rd_stb || wr_stb;

    a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(valid && err));

    a_r12_quiet_after_idle: assert property (@(posedge clk) disable iff (rst)
        !(fetch_req || any_word) |=> (!valid && !err));

    a_r9_word_oob_err: assert property (@(posedge clk) disable iff (rst)
        (any_word && word_oob) |=> (err && !valid));

    a_r9_oob_read_keeps: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && word_oob) |=> $stable(rdata));

    a_r10_word_first: assert property (@(posedge clk) disable iff (rst)
        any_word |=> $stable(fetch_byte));

    a_r8_fetch_oob: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !any_word && fetch_oob) |=> (err && $stable(fetch_byte)));

    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && wr_stb) |=> $stable(rdata));

    a_r4_inrange_read_valid: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !word_oob) |=> (valid && !err));
endmodule

bind wob_mem wob_mem_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/wob_mem_test.sv
module wob_mem_test;
    localparam int DEPTH  = 4998;
    localparam int ADDR_W = 13;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fetch_req = 1'b0;
    logic [ADDR_W-1:0] fetch_addr = '0;
    logic              rd_stb = 1'b0;
    logic              wr_stb = 1'b0;
    logic [ADDR_W-1:0] word_addr = '0;
    logic [31:0]       wdata = '0;
    logic [7:0]        fetch_byte;
    logic [31:0]       rdata;
    logic              valid;
    logic              err;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0]  exp_fb = 8'h00;
    logic [31:0] exp_rd = 32'h0;

    always #10 clk = ~clk;

    wob_mem #(
        .DEPTH    (DEPTH),
        .ADDR_W   (ADDR_W),
        .IMAGE_LEN(4),
        .IMAGE    (32'hC35AA510)
    ) uut (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge; results are seen at the next falling edge
    task automatic cycle(input logic f, input int fa, input logic r, input logic w,
                         input int wa, input logic [31:0] wd);
        fetch_req  = f;
        fetch_addr = ADDR_W'(fa);
        rd_stb     = r;
        wr_stb     = w;
        word_addr  = ADDR_W'(wa);
        wdata      = wd;
        @(negedge clk);
        fetch_req = 1'b0;
        rd_stb    = 1'b0;
        wr_stb    = 1'b0;
    endtask

    task automatic do_fetch(input string req, input int a, input logic [7:0] exp);
        cycle(1'b1, a, 1'b0, 1'b0, 0, 32'h0);
        exp_fb = exp;
        check({req, " fetch valid"}, 32'(valid), 32'd1);
        check({req, " fetch byte"}, 32'(fetch_byte), 32'(exp));
    endtask

    task automatic do_read(input string req, input int wa, input logic [31:0] exp);
        cycle(1'b0, 0, 1'b1, 1'b0, wa, 32'h0);
        exp_rd = exp;
        check({req, " read valid"}, 32'(valid), 32'd1);
        check({req, " read word"}, rdata, exp);
    endtask

    task automatic do_write(input string req, input int wa, input logic [31:0] d);
        cycle(1'b0, 0, 1'b0, 1'b1, wa, d);
        check({req, " write valid"}, 32'(valid), 32'd1);
    endtask

    task automatic t_reset();
        check("R1 valid", 32'(valid), 32'd0);
        check("R1 err", 32'(err), 32'd0);
        check("R1 rdata", rdata, 32'h0);
        check("R1 fetch_byte", 32'(fetch_byte), 32'd0);
    endtask

    task automatic t_image();
        do_fetch("R7 byte0", 0, 8'h10);
        do_fetch("R7 byte1", 1, 8'hA5);
        do_fetch("R5 byte3", 3, 8'hC3);
        do_read("R4 R7 word0", 0, 32'h10A55AC3);
    endtask

    task automatic t_unwritten();
        do_fetch("R6 byte100", 100, 8'h00);
        do_read("R6 word10", 10, 32'h0);
        do_fetch("R6 byte4", 4, 8'h00);
    endtask

    task automatic t_layout();
        do_write("R3", 5, 32'hDEADBEEF);
        do_fetch("R3 msb at 4W", 20, 8'hDE);
        do_fetch("R3 lane1", 21, 8'hAD);
        do_fetch("R3 lsb at 4W+3", 23, 8'hEF);
        do_fetch("R2 below", 19, 8'h00);
        do_fetch("R2 above", 24, 8'h00);
        do_read("R4 readback", 5, 32'hDEADBEEF);
    endtask

    task automatic t_fetch_bound();
        do_fetch("R8 last byte", DEPTH - 1, 8'h00);
        do_fetch("R5 known", 22, 8'hBE);
        cycle(1'b1, DEPTH, 1'b0, 1'b0, 0, 32'h0);
        check("R8 err at DEPTH", 32'(err), 32'd1);
        check("R8 no valid", 32'(valid), 32'd0);
        check("R8 byte held", 32'(fetch_byte), 32'(exp_fb));
        cycle(1'b1, (1 << ADDR_W) - 1, 1'b0, 1'b0, 0, 32'h0);
        check("R8 err at top", 32'(err), 32'd1);
    endtask

    task automatic t_word_bound();
        do_write("R9 last full", 1248, 32'h01020304);
        do_fetch("R9 byte4995", 4995, 8'h04);
        cycle(1'b0, 0, 1'b0, 1'b1, 1249, 32'hAABBCCDD);
        check("R9 partial write err", 32'(err), 32'd1);
        check("R9 partial write no valid", 32'(valid), 32'd0);
        do_fetch("R9 byte4996 untouched", 4996, 8'h00);
        do_fetch("R9 byte4997 untouched", 4997, 8'h00);
        cycle(1'b0, 0, 1'b1, 1'b0, 1249, 32'h0);
        check("R9 partial read err", 32'(err), 32'd1);
        check("R9 rdata held", rdata, exp_rd);
        cycle(1'b0, 0, 1'b1, 1'b0, 2000, 32'h0);
        check("R9 far read err", 32'(err), 32'd1);
    endtask

    task automatic t_priority();
        do_fetch("R10 prime", 0, 8'h10);
        cycle(1'b1, 20, 1'b1, 1'b0, 1248, 32'h0);
        exp_rd = 32'h01020304;
        check("R10 word served", rdata, exp_rd);
        check("R10 valid", 32'(valid), 32'd1);
        check("R10 fetch_byte held", 32'(fetch_byte), 32'(exp_fb));
        cycle(1'b0, 0, 1'b1, 1'b1, 6, 32'h11223344);
        check("R11 rdata held", rdata, exp_rd);
        check("R11 valid", 32'(valid), 32'd1);
        do_read("R11 write done", 6, 32'h11223344);
    endtask

    task automatic t_pulses();
        do_fetch("R12 setup", 21, 8'hAD);
        cycle(1'b0, 0, 1'b0, 1'b0, 0, 32'h0);
        check("R12 valid drops", 32'(valid), 32'd0);
        check("R12 err low", 32'(err), 32'd0);
        check("R12 rdata held", rdata, exp_rd);
        check("R12 fetch_byte held", 32'(fetch_byte), 32'(exp_fb));
        cycle(1'b1, DEPTH + 5, 1'b0, 1'b0, 0, 32'h0);
        cycle(1'b0, 0, 1'b0, 1'b0, 0, 32'h0);
        check("R12 err drops", 32'(err), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_image();
        t_unwritten();
        t_layout();
        t_fetch_bound();
        t_word_bound();
        t_priority();
        t_pulses();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule